// File: doc/BRIEF.md
# SPI Master Engine with Single-Bit Prepend Phase

This block runs one SPI command at a time from a small shared byte buffer. The host fills the buffer with a two-byte command word, then an optional run of preamble bytes (opcode, address, dummy bytes), then any transmit payload. The host also programs a per-profile preamble count. A command is launched by pulsing start together with a chip-select index and a profile index. The engine drives the selected chip select low, shifts the preamble bytes out on a single data line, and then runs the payload as write, read or full-duplex.

A write-only or read-only payload can use two data lines. The two-line window opens exactly at the end of the preamble, so an instruction and address go out on one line and the data moves on two lines, all under one chip-select assertion. Chip select is held active only while a command runs and is never left low across commands. Received payload bytes are written back into the buffer from offset 0. A busy flag covers the whole command. A sticky completion flag, gated by an enable, raises the interrupt. Malformed or oversized commands and starts issued while busy are refused and recorded in sticky error flags.

The SPI timing is mode 0, most significant bit first, with 8-bit bytes and a simple divided clock.

Top module: `spi_pp_master`

## Requirements
- R1: The command word is buffer byte 0 (high half) followed by byte 1 (low half). Bits 15:14 are the opcode (01 write, 10 read, 11 full-duplex). Bit 13 requests two-line payload, bit 12 must be zero, and bits 11:0 give the payload length in bytes.
- R2: The preamble count is the 4-bit value held for the profile chosen at start. Preamble bytes are taken from buffer offsets 2 upward and sent MSB first on io0 before any payload byte, with output enable 01.
- R3: A write payload is taken from buffer offset 2 plus the preamble count. In single-line mode it goes out on io0, changing only while sclk is low so it is stable at each rising edge.
- R4: A read payload in single-line mode samples io1 at each rising sclk edge and stores payload byte j at buffer offset j. During read payload bytes io0 is driven low.
- R5: A full-duplex payload transmits and receives at the same time on one line each. The two-line request bit is ignored for this opcode.
- R6: A two-line write payload sends two bits per clock, with io1 carrying bits 7, 5, 3 and 1 and io0 carrying bits 6, 4, 2 and 0, and output enable 11.
- R7: A two-line read payload releases both lines (output enable 00), samples two bits per clock with io1 as the more significant bit, and stores the bytes from buffer offset 0.
- R8: Only the selected chip select (active low) is driven low, and only while a command runs. All chip selects are high and sclk is low when idle.
- R9: Busy reads 1 from the cycle after an accepted start until the end of the command. A start while busy is ignored and sets a sticky busy-error flag, which only the clear input resets.
- R10: A start whose opcode is 00, whose reserved bit is set, or whose preamble plus payload length is 0 or exceeds the buffer size minus 2 is refused. Chip select stays high, busy stays low, and a sticky command-error flag is set.
- R11: The end of a command sets a pending flag that stays set until acknowledged. The interrupt output is the pending flag ANDed with the enable input.
- R12: Each sclk half period lasts CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | AW | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data at buf_addr |
| mode_we | input | 1 | Profile preamble-count write strobe |
| mode_sel | input | PW | Profile written by mode_we |
| mode_pre | input | PRE_W | Preamble count written |
| cmd_start | input | 1 | Launch command pulse |
| cmd_cs | input | CSW | Chip-select index for the command |
| cmd_profile | input | PW | Profile index for the command |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the completion pending flag |
| err_clr | input | 1 | Clears both sticky error flags |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion interrupt |
| err_busy | output | 1 | Sticky: start arrived while busy |
| err_cmd | output | 1 | Sticky: malformed or oversized command refused |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_o | output | 2 | Data line outputs (io1, io0) |
| spi_io_oe | output | 2 | Data line output enables |
| spi_io_i | input | 2 | Data line inputs (io1, io0) |

## Verification
The assertions assume that the host leaves the buffer and the profile counts untouched while busy is high. They also assume that the attached target changes its data lines only after a rising sclk edge, so the value is settled when the engine samples at the next rise. The bench writes the buffer and profile registers only between commands. Its target model updates io_i immediately after each rising sclk edge from a per-edge table built before the start pulse. Start pulses during a command are the only host activity the bench issues while busy is high.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;

   // payload opcode: bit 0 = transmit payload, bit 1 = receive payload
   localparam logic [1:0] OP_NONE = 2'b00;
   localparam logic [1:0] OP_WR   = 2'b01;
   localparam logic [1:0] OP_RD   = 2'b10;
   localparam logic [1:0] OP_RW   = 2'b11;

   localparam int HDR_BYTES = 2;
   localparam int LEN_W     = 12;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [1:0]       op;
      logic             dual;
      logic             rsvd;
      logic [LEN_W-1:0] len;
   } cmd_word_t;

endpackage

// File: rtl/spi_pp_buffer.sv
module spi_pp_buffer #(
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   input  logic [AW-1:0] eng_raddr,
   output logic [7:0]    eng_rdata,
   input  logic          eng_we,
   input  logic [AW-1:0] eng_waddr,
   input  logic [7:0]    eng_wdata,
   output logic [15:0]   cmd_word
);

   logic [7:0] mem_q [DEPTH];

   // engine write-back takes the port when both ask in one cycle
   always_ff @(posedge clk) begin
      if (eng_we)
         mem_q[eng_waddr] <= eng_wdata;
      else if (host_we)
         mem_q[host_addr] <= host_wdata;
   end

   assign host_rdata = mem_q[host_addr];
   assign eng_rdata  = mem_q[eng_raddr];
   assign cmd_word   = {mem_q[0], mem_q[1]};

endmodule

// File: rtl/spi_pp_sclk_gen.sv
module spi_pp_sclk_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);

   logic wrap;

   generate
      if (CLK_DIV == 1) begin : g_div1
         assign wrap = en;
      end else begin : g_divn
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!en || wrap)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign wrap = en && (cnt_q == CW'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sclk <= 1'b0;
      else if (!en)
         sclk <= 1'b0;
      else if (wrap)
         sclk <= ~sclk;
   end

   assign rise_tick = wrap && !sclk;
   assign fall_tick = wrap && sclk;

   initial assert (CLK_DIV >= 1) else $error("CLK_DIV must be at least 1");

   // R12: with the divider stopped the clock rests low
   p_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sclk);

endmodule

// File: rtl/spi_pp_seq.sv
module spi_pp_seq
   import spi_pp_pkg::*;
#(
   parameter int BUF_BYTES = 32,
   parameter int NUM_CS    = 4,
   parameter int PRE_W     = 4,
   parameter int AW        = 5,
   parameter int CSW       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [CSW-1:0]    cmd_cs,
   input  logic [PRE_W-1:0]  pre_in,
   input  logic [15:0]       cmd_word,
   input  logic [7:0]        eng_rdata,
   output logic [AW-1:0]     eng_raddr,
   output logic              eng_we,
   output logic [AW-1:0]     eng_waddr,
   output logic [7:0]        eng_wdata,
   input  logic              rise_tick,
   input  logic              fall_tick,
   output logic              sclk_en,
   input  logic [1:0]        io_i,
   output logic [1:0]        io_o,
   output logic [1:0]        io_oe,
   output logic [NUM_CS-1:0] cs_n,
   input  logic              irq_en,
   input  logic              irq_ack,
   input  logic              err_clr,
   output logic              busy,
   output logic              irq,
   output logic              err_busy,
   output logic              err_cmd
);

   localparam int IW = AW + 1;

   seq_state_e       st_q;
   logic [1:0]       op_q;
   logic             dual_q;
   logic [PRE_W-1:0] pre_q;
   logic [IW-1:0]    tot_q;
   logic [IW-1:0]    idx_q;
   logic [2:0]       cyc_q;
   logic [7:0]       tx_q;
   logic [7:0]       rx_q;
   logic [NUM_CS-1:0] cs_n_q;
   logic             irq_q;
   logic             eb_q;
   logic             ec_q;

   // command word decode at launch
   cmd_word_t          cw;
   logic [LEN_W:0]     tot_req;
   logic               cmd_ok;
   assign cw      = cmd_word_t'(cmd_word);
   assign tot_req = {1'b0, cw.len} + (LEN_W+1)'(pre_in);
   assign cmd_ok  = (cw.op != OP_NONE) && !cw.rsvd && (tot_req != '0) &&
                    (tot_req <= (LEN_W+1)'(BUF_BYTES - HDR_BYTES));

   // per-byte phase
   logic [IW-1:0] pre_ext;
   logic          in_pay;
   logic          byte_dual;
   logic [2:0]    cyc_last;
   logic          last_byte;
   logic [IW-1:0] nidx;
   logic [7:0]    tx_val;

   assign pre_ext   = IW'(pre_q);
   assign in_pay    = idx_q >= pre_ext;
   assign byte_dual = dual_q && in_pay && (op_q != OP_RW);
   assign cyc_last  = byte_dual ? 3'd3 : 3'd7;
   assign last_byte = (idx_q == tot_q - 1'b1);
   assign nidx      = (st_q == ST_SETUP) ? '0 : idx_q + 1'b1;
   assign eng_raddr = AW'(nidx + IW'(HDR_BYTES));
   assign tx_val    = ((nidx < pre_ext) || op_q[0]) ? eng_rdata : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_NONE;
         dual_q <= 1'b0;
         pre_q  <= '0;
         tot_q  <= '0;
         idx_q  <= '0;
         cyc_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         cs_n_q <= '1;
         irq_q  <= 1'b0;
         eb_q   <= 1'b0;
         ec_q   <= 1'b0;
      end else begin
         if (err_clr) begin
            eb_q <= 1'b0;
            ec_q <= 1'b0;
         end
         if (irq_ack)
            irq_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (cmd_start) begin
                  if (cmd_ok) begin
                     st_q   <= ST_SETUP;
                     op_q   <= cw.op;
                     dual_q <= cw.dual;
                     pre_q  <= pre_in;
                     tot_q  <= IW'(tot_req);
                     idx_q  <= '0;
                     cyc_q  <= '0;
                     cs_n_q <= ~(NUM_CS'(1) << cmd_cs);
                  end else begin
                     ec_q <= 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               tx_q <= tx_val;
               st_q <= ST_SHIFT;
            end
            default: begin
               if (rise_tick)
                  rx_q <= byte_dual ? {rx_q[5:0], io_i} : {rx_q[6:0], io_i[1]};
               if (fall_tick) begin
                  if (cyc_q == cyc_last) begin
                     if (last_byte) begin
                        st_q   <= ST_IDLE;
                        cs_n_q <= '1;
                        irq_q  <= 1'b1;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                        cyc_q <= '0;
                        tx_q  <= tx_val;
                     end
                  end else begin
                     cyc_q <= cyc_q + 1'b1;
                     tx_q  <= byte_dual ? {tx_q[5:0], 2'b00} : {tx_q[6:0], 1'b0};
                  end
               end
            end
         endcase
         if (cmd_start && (st_q != ST_IDLE))
            eb_q <= 1'b1;
      end
   end

   // received payload write-back, one byte per completed payload byte
   assign eng_we    = (st_q == ST_SHIFT) && fall_tick && (cyc_q == cyc_last) &&
                      in_pay && op_q[1];
   assign eng_waddr = AW'(idx_q - pre_ext);
   assign eng_wdata = rx_q;

   // data line drive
   always_comb begin
      io_o  = 2'b00;
      io_oe = 2'b01;
      if (st_q == ST_SHIFT) begin
         if (byte_dual) begin
            io_o  = {tx_q[7], tx_q[6]};
            io_oe = (op_q == OP_RD) ? 2'b00 : 2'b11;
         end else begin
            io_o = {1'b0, tx_q[7]};
         end
      end
   end

   assign sclk_en  = (st_q == ST_SHIFT);
   assign cs_n     = cs_n_q;
   assign busy     = (st_q != ST_IDLE);
   assign irq      = irq_q && irq_en;
   assign err_busy = eb_q;
   assign err_cmd  = ec_q;

   // R9: a start during a command is flagged
   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && busy && !err_clr) |=> err_busy);

   // R8: no chip select active while idle, never more than one
   p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cs_n));
   p_one_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R10: a refused launch leaves the engine idle
   p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy && !cmd_ok) |=> (!busy && err_cmd));

   // R11: every command end leaves a pending completion
   p_done_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_q);

   // R7: lines are released only inside a command
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe == 2'b00) |-> busy);

   // R4: write-back never reaches past the payload region
   p_wb_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |-> (eng_waddr < AW'(BUF_BYTES - HDR_BYTES)));

endmodule

// File: rtl/spi_pp_master.sv
module spi_pp_master
   import spi_pp_pkg::*;
#(
   parameter int BUF_BYTES = 32,
   parameter int NUM_CS    = 4,
   parameter int NUM_PROF  = 4,
   parameter int CLK_DIV   = 2,
   parameter int PRE_W     = 4,
   localparam int AW       = $clog2(BUF_BYTES),
   localparam int CSW      = $clog2(NUM_CS),
   localparam int PW       = $clog2(NUM_PROF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_we,
   input  logic [AW-1:0]     buf_addr,
   input  logic [7:0]        buf_wdata,
   output logic [7:0]        buf_rdata,
   input  logic              mode_we,
   input  logic [PW-1:0]     mode_sel,
   input  logic [PRE_W-1:0]  mode_pre,
   input  logic              cmd_start,
   input  logic [CSW-1:0]    cmd_cs,
   input  logic [PW-1:0]     cmd_profile,
   input  logic              irq_en,
   input  logic              irq_ack,
   input  logic              err_clr,
   output logic              busy,
   output logic              irq,
   output logic              err_busy,
   output logic              err_cmd,
   output logic              spi_sclk,
   output logic [NUM_CS-1:0] spi_cs_n,
   output logic [1:0]        spi_io_o,
   output logic [1:0]        spi_io_oe,
   input  logic [1:0]        spi_io_i
);

   initial begin
      assert (BUF_BYTES >= 4 && (1 << AW) == BUF_BYTES)
         else $error("BUF_BYTES must be a power of two, at least 4");
      assert (NUM_CS >= 2 && (1 << CSW) == NUM_CS)
         else $error("NUM_CS must be a power of two, at least 2");
      assert (NUM_PROF >= 2 && (1 << PW) == NUM_PROF)
         else $error("NUM_PROF must be a power of two, at least 2");
      assert (PRE_W >= 1 && PRE_W <= AW + 1)
         else $error("PRE_W out of range");
   end

   // per-profile preamble counts
   logic [PRE_W-1:0] mode_q [NUM_PROF];

   generate
      for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q[p] <= '0;
            else if (mode_we && (mode_sel == PW'(p)))
               mode_q[p] <= mode_pre;
         end
      end
   endgenerate

   logic [15:0]   cmd_word;
   logic [7:0]    eng_rdata;
   logic [AW-1:0] eng_raddr;
   logic          eng_we;
   logic [AW-1:0] eng_waddr;
   logic [7:0]    eng_wdata;
   logic          sclk_en;
   logic          rise_tick;
   logic          fall_tick;

   spi_pp_buffer #(
      .DEPTH (BUF_BYTES),
      .AW    (AW)
   ) u_buf (
      .clk        (clk),
      .host_we    (buf_we),
      .host_addr  (buf_addr),
      .host_wdata (buf_wdata),
      .host_rdata (buf_rdata),
      .eng_raddr  (eng_raddr),
      .eng_rdata  (eng_rdata),
      .eng_we     (eng_we),
      .eng_waddr  (eng_waddr),
      .eng_wdata  (eng_wdata),
      .cmd_word   (cmd_word)
   );

   spi_pp_sclk_gen #(
      .CLK_DIV (CLK_DIV)
   ) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (sclk_en),
      .sclk      (spi_sclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   spi_pp_seq #(
      .BUF_BYTES (BUF_BYTES),
      .NUM_CS    (NUM_CS),
      .PRE_W     (PRE_W),
      .AW        (AW),
      .CSW       (CSW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_cs    (cmd_cs),
      .pre_in    (mode_q[cmd_profile]),
      .cmd_word  (cmd_word),
      .eng_rdata (eng_rdata),
      .eng_raddr (eng_raddr),
      .eng_we    (eng_we),
      .eng_waddr (eng_waddr),
      .eng_wdata (eng_wdata),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .sclk_en   (sclk_en),
      .io_i      (spi_io_i),
      .io_o      (spi_io_o),
      .io_oe     (spi_io_oe),
      .cs_n      (spi_cs_n),
      .irq_en    (irq_en),
      .irq_ack   (irq_ack),
      .err_clr   (err_clr),
      .busy      (busy),
      .irq       (irq),
      .err_busy  (err_busy),
      .err_cmd   (err_cmd)
   );

   // R8: the SPI clock only toggles with a chip select active
   p_sclk_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> (spi_cs_n != '1));

endmodule

// File: tb/spi_pp_master_tb_top.sv
`timescale 1ns/1ps
module spi_pp_master_tb_top;

   localparam int BUF_BYTES = 32;
   localparam int NUM_CS    = 4;
   localparam int NUM_PROF  = 4;
   localparam int CLK_DIV   = 2;
   localparam int PRE_W     = 4;
   localparam int AW        = $clog2(BUF_BYTES);
   localparam int CSW       = $clog2(NUM_CS);
   localparam int PW        = $clog2(NUM_PROF);

   typedef struct packed {
      logic [1:0] op;
      logic       dual;
      logic [1:0] cs;
      logic [1:0] prof;
      logic [3:0] pre;
      logic [7:0] len;
      logic [7:0] seed;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 1'b0, 2'd0, 2'd0, 4'd0,  8'd4,  8'h11},
      '{2'd1, 1'b0, 2'd1, 2'd1, 4'd3,  8'd5,  8'h22},
      '{2'd2, 1'b0, 2'd2, 2'd2, 4'd1,  8'd3,  8'h33},
      '{2'd2, 1'b0, 2'd3, 2'd3, 4'd0,  8'd2,  8'h44},
      '{2'd3, 1'b0, 2'd0, 2'd1, 4'd2,  8'd4,  8'h55},
      '{2'd1, 1'b1, 2'd1, 2'd2, 4'd4,  8'd3,  8'h66},
      '{2'd2, 1'b1, 2'd2, 2'd3, 4'd1,  8'd4,  8'h77},
      '{2'd3, 1'b1, 2'd3, 2'd0, 4'd0,  8'd3,  8'h88},
      '{2'd1, 1'b0, 2'd0, 2'd2, 4'd15, 8'd15, 8'h99},
      '{2'd2, 1'b1, 2'd1, 2'd1, 4'd15, 8'd1,  8'hAA},
      '{2'd1, 1'b1, 2'd2, 2'd0, 4'd0,  8'd2,  8'hBB}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              buf_we;
   logic [AW-1:0]     buf_addr;
   logic [7:0]        buf_wdata;
   logic [7:0]        buf_rdata;
   logic              mode_we;
   logic [PW-1:0]     mode_sel;
   logic [PRE_W-1:0]  mode_pre;
   logic              cmd_start;
   logic [CSW-1:0]    cmd_cs;
   logic [PW-1:0]     cmd_profile;
   logic              irq_en;
   logic              irq_ack;
   logic              err_clr;
   logic              busy;
   logic              irq;
   logic              err_busy;
   logic              err_cmd;
   logic              spi_sclk;
   logic [NUM_CS-1:0] spi_cs_n;
   logic [1:0]        spi_io_o;
   logic [1:0]        spi_io_oe;
   logic [1:0]        spi_io_i;

   always #5 clk = ~clk;

   spi_pp_master #(
      .BUF_BYTES (BUF_BYTES),
      .NUM_CS    (NUM_CS),
      .NUM_PROF  (NUM_PROF),
      .CLK_DIV   (CLK_DIV),
      .PRE_W     (PRE_W)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .buf_we (buf_we), .buf_addr (buf_addr), .buf_wdata (buf_wdata),
      .buf_rdata (buf_rdata),
      .mode_we (mode_we), .mode_sel (mode_sel), .mode_pre (mode_pre),
      .cmd_start (cmd_start), .cmd_cs (cmd_cs), .cmd_profile (cmd_profile),
      .irq_en (irq_en), .irq_ack (irq_ack), .err_clr (err_clr),
      .busy (busy), .irq (irq), .err_busy (err_busy), .err_cmd (err_cmd),
      .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n),
      .spi_io_o (spi_io_o), .spi_io_oe (spi_io_oe), .spi_io_i (spi_io_i)
   );

   // target model: per-edge recording and per-edge response table
   int               sclk_cnt = 0;
   int               base     = 0;
   logic [1:0]       miso_tab [256];
   logic [1:0]       rec_io   [256];
   logic [1:0]       rec_oe   [256];
   logic [NUM_CS-1:0] rec_cs  [256];

   assign spi_io_i = miso_tab[8'(sclk_cnt - base)];

   always @(posedge spi_sclk) begin
      rec_io[8'(sclk_cnt - base)] = spi_io_o;
      rec_oe[8'(sclk_cnt - base)] = spi_io_oe;
      rec_cs[8'(sclk_cnt - base)] = spi_cs_n;
      sclk_cnt = sclk_cnt + 1;
   end

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic host_wr(input int a, input logic [7:0] d);
      buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
      tick();
      buf_we = 1'b0;
   endtask

   task automatic host_rd(input int a, output logic [7:0] d);
      buf_addr = AW'(a);
      #1 d = buf_rdata;
   endtask

   task automatic set_mode(input int p, input int pre);
      mode_we = 1'b1; mode_sel = PW'(p); mode_pre = PRE_W'(pre);
      tick();
      mode_we = 1'b0;
   endtask

   task automatic pulse_start(input int cs, input int p);
      cmd_start = 1'b1; cmd_cs = CSW'(cs); cmd_profile = PW'(p);
      tick();
      cmd_start = 1'b0;
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      while (busy && n < 5000) begin
         tick();
         n++;
      end
      if (busy) chk(1'b0, "R9 command never ended", 1, 0);
   endtask

   task automatic write_cmd(input logic [1:0] op, input logic dual, input int len);
      host_wr(0, {op, dual, 1'b0, 4'(len >> 8)});
      host_wr(1, 8'(len));
   endtask

   function automatic logic [7:0] txb(input logic [7:0] s, input int i);
      return (s + 8'(i * 8'h37)) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] rxb(input logic [7:0] s, input int j);
      return ~s ^ 8'(j * 8'h29) ^ 8'h0F;
   endfunction

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      realtime    t0;
      realtime    t1;
      logic [NUM_CS-1:0] cs_before;

      for (int i = 0; i < 256; i++) miso_tab[i] = 2'b00;
      rst_n = 1'b0; buf_we = 1'b0; buf_addr = '0; buf_wdata = '0;
      mode_we = 1'b0; mode_sel = '0; mode_pre = '0;
      cmd_start = 1'b0; cmd_cs = '0; cmd_profile = '0;
      irq_en = 1'b1; irq_ack = 1'b0; err_clr = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      chk(spi_cs_n == '1, "R8 reset chip selects", int'(spi_cs_n), 15);
      chk(spi_sclk == 1'b0, "R8 reset sclk", int'(spi_sclk), 0);
      chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
      chk(irq == 1'b0, "R11 reset irq", int'(irq), 0);
      chk(err_busy == 1'b0 && err_cmd == 1'b0, "R10 reset errors",
          int'({err_busy, err_cmd}), 0);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         vec_t cv;
         int P, L, T, ne, e, m_tx, m_oe, m_cs, m_rx;
         cv = VECS[v];
         P = int'(cv.pre); L = int'(cv.len); T = P + L;
         set_mode(int'(cv.prof), P);
         write_cmd(cv.op, cv.dual, L);
         for (int i = 0; i < T; i++) host_wr(2 + i, txb(cv.seed, i));
         ne = 0;
         for (int k = 0; k < T; k++) begin
            bit pay, dl;
            logic [7:0] r;
            pay = (k >= P);
            dl  = cv.dual && pay && (cv.op != 2'd3);
            r   = pay ? rxb(cv.seed, k - P) : 8'hFF;
            if (dl) for (int c = 0; c < 4; c++) begin
               miso_tab[ne] = {r[7 - 2*c], r[6 - 2*c]}; ne++;
            end else for (int c = 0; c < 8; c++) begin
               miso_tab[ne] = {r[7 - c], 1'b0}; ne++;
            end
         end
         base = sclk_cnt;
         pulse_start(int'(cv.cs), int'(cv.prof));
         wait_idle();

         // R1 R2: edge count follows the command word and the profile count
         chk((sclk_cnt - base) == ne, "R1 R2 sclk edge count", sclk_cnt - base, ne);

         e = 0; m_tx = 0; m_oe = 0; m_cs = 0;
         for (int k = 0; k < T; k++) begin
            bit pay, dl;
            logic [7:0] b, xb;
            logic [1:0] eoe;
            pay = (k >= P);
            dl  = cv.dual && pay && (cv.op != 2'd3);
            xb  = (!pay || cv.op[0]) ? txb(cv.seed, k) : 8'h00;
            eoe = !dl ? 2'b01 : (cv.op == 2'd2 ? 2'b00 : 2'b11);
            b = '0;
            for (int c = 0; c < (dl ? 4 : 8); c++) begin
               if (dl) b = {b[5:0], rec_io[e]};
               else    b = {b[6:0], rec_io[e][0]};
               if (rec_oe[e] != eoe) m_oe++;
               if (rec_cs[e] != ~(NUM_CS'(1) << cv.cs)) m_cs++;
               e++;
            end
            if (dl && cv.op == 2'd2) b = xb;
            if (b != xb) m_tx++;
         end
         chk(m_tx == 0, "R2 R3 R4 R6 transmitted bytes", m_tx, 0);
         chk(m_oe == 0, "R2 R6 R7 output enables", m_oe, 0);
         chk(m_cs == 0, "R8 chip select during command", m_cs, 0);

         m_rx = 0;
         if (cv.op[1]) begin
            for (int j = 0; j < L; j++) begin
               host_rd(j, rd);
               if (rd != rxb(cv.seed, j)) m_rx++;
            end
            chk(m_rx == 0, "R4 R5 R7 received bytes", m_rx, 0);
         end
         tick();
         chk(spi_cs_n == '1 && !spi_sclk, "R8 idle after command",
             int'({spi_sclk, spi_cs_n}), 15);
         chk(irq == 1'b1, "R11 completion interrupt", int'(irq), 1);
         irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      end

      // R12 half period, R9 busy timing and start while busy
      set_mode(0, 2);
      write_cmd(2'd1, 1'b0, 6);
      pulse_start(1, 0);
      chk(busy == 1'b1, "R9 busy after accepted start", int'(busy), 1);
      @(posedge spi_sclk); t0 = $realtime;
      @(negedge spi_sclk); t1 = $realtime;
      chk(int'(t1 - t0) == CLK_DIV * 10, "R12 sclk half period",
          int'(t1 - t0), CLK_DIV * 10);
      tick();
      cs_before = spi_cs_n;
      pulse_start(3, 1);
      chk(err_busy == 1'b1, "R9 start while busy flagged", int'(err_busy), 1);
      chk(spi_cs_n == cs_before, "R9 start while busy ignored",
          int'(spi_cs_n), int'(cs_before));
      wait_idle();
      tick();
      chk(err_busy == 1'b1, "R9 busy error is sticky", int'(err_busy), 1);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk(err_busy == 1'b0, "R9 clear of busy error", int'(err_busy), 0);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;

      // R10 oversize by one byte
      set_mode(1, 15);
      write_cmd(2'd1, 1'b0, 16);
      pulse_start(0, 1);
      chk(busy == 1'b0 && spi_cs_n == '1, "R10 oversize refused",
          int'({busy, spi_cs_n}), 15);
      chk(err_cmd == 1'b1, "R10 oversize flagged", int'(err_cmd), 1);
      err_clr = 1'b1; tick(); err_clr = 1'b0;

      // R1 R10 upper length bits live in byte 0
      set_mode(0, 0);
      write_cmd(2'd1, 1'b0, 257);
      pulse_start(0, 0);
      chk(busy == 1'b0 && err_cmd == 1'b1, "R1 R10 long length refused",
          int'({busy, err_cmd}), 1);
      err_clr = 1'b1; tick(); err_clr = 1'b0;

      // R10 empty opcode
      write_cmd(2'd0, 1'b0, 3);
      pulse_start(2, 0);
      chk(busy == 1'b0 && err_cmd == 1'b1, "R10 opcode 00 refused",
          int'({busy, err_cmd}), 1);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk(err_cmd == 1'b0, "R10 clear of command error", int'(err_cmd), 0);

      // R11 enable gating and acknowledge
      irq_en = 1'b0;
      write_cmd(2'd1, 1'b0, 1);
      pulse_start(0, 0);
      wait_idle();
      tick();
      chk(irq == 1'b0, "R11 interrupt masked", int'(irq), 0);
      irq_en = 1'b1;
      #1 chk(irq == 1'b1, "R11 pending kept while masked", int'(irq), 1);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk(irq == 1'b0, "R11 acknowledge clears", int'(irq), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule